// File: doc/BRIEF.md
# PS/2 Keyboard Host Receiver with LED Command

This block sits on the host side of a two-wire PS/2 keyboard link. It brings the open-collector clock and data lines into the system clock domain and detects falling edges of the keyboard clock. On each falling edge it shifts in one bit. After eleven bits it checks the frame. Good bytes go to a prefix decoder. That decoder remembers the extended (E0) and release (F0) prefixes and emits one key event for each final scan code. The event carries the code plus a release flag and an extended flag.

The block can also set the keyboard's indicator LEDs. One pulse on `led_req` starts a full exchange. The host inhibits the bus, sends the ED command, and waits for the FA answer. It then sends the three-bit LED mask and waits for a second FA. The bus drivers are open-collector enables: when an enable is high, the host pulls that line low.

Top module: `ps2_kbd_host`

## Requirements
- R1: A frame is one start bit (0), eight data bits with the LSB first, one odd parity bit and one stop bit (1). Each bit is sampled on a falling edge of the keyboard clock. A valid frame whose byte is neither E0 nor F0 produces a one-cycle `key_valid` with `key_code` equal to that byte.
- R2: A byte F0 is not reported. It sets `key_break` to 1 on the next reported event.
- R3: A byte E0 is not reported. It sets `key_ext` to 1 on the next reported event, and E0 F0 sets both flags. `key_code` is never E0 or F0 while `key_valid` is high. Both flags clear after each event.
- R4: A frame with start bit 1, stop bit 0 or even parity gives a one-cycle `frame_err` and no event.
- R5: If GAP_CYC system cycles pass with no falling clock edge, a partly received frame and any pending prefix are discarded.
- R6: An LED exchange first holds the clock low (`ps2_clk_oe`=1) for at least INHIBIT_CYC cycles. It pulls data low while the clock is still held, and only then releases the clock.
- R7: The host sends ED and then the byte {5'b0, mask}, each with odd parity and a stop bit. It changes its data output on the device's falling clock edges. Each byte is sent only after an FA answer, and FA answers received during the exchange are not reported as events.
- R8: If any byte other than FA arrives while an answer is awaited, the exchange ends, `led_busy` falls and the byte is dropped.
- R9: `led_busy` is high from the cycle after an accepted request until the exchange ends. A request made while busy is ignored. Both bus enables are low whenever `led_busy` is low.
- R10: After reset, no line is driven, `led_busy` is low and no event or error is pending.
- R11: `key_valid` and `frame_err` are single-cycle pulses and never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ps2_clk_i | input | 1 | Keyboard clock line as seen at the pin |
| ps2_data_i | input | 1 | Keyboard data line as seen at the pin |
| ps2_clk_oe | output | 1 | 1 pulls the clock line low |
| ps2_data_oe | output | 1 | 1 pulls the data line low |
| led_req | input | 1 | Pulse to start an LED exchange |
| led_mask | input | 3 | bit0 scroll, bit1 num, bit2 caps |
| led_busy | output | 1 | LED exchange in progress |
| key_valid | output | 1 | One-cycle key event strobe |
| key_code | output | 8 | Scan code of the event |
| key_break | output | 1 | Event is a key release |
| key_ext | output | 1 | Event is an extended key |
| frame_err | output | 1 | One-cycle pulse on a bad frame |

## Verification
The bench sweeps every plain scan code, and crosses a spread of codes with each prefix pattern. A decoder that leaked a prefix into the following event, or that reported E0 or F0 as a key, would show a wrong flag or an extra event. Each of the three kinds of framing fault is injected: a design that skipped any one check would report a key instead of an error. A pending E0 and a cut-off frame are both left to time out; a missing gap timer would turn the next key extended or shift it by bits. All eight LED masks are run through a model keyboard that checks parity, stop bit and inhibit length. A wrong answer in place of FA and a second request made while busy must end or leave the exchange unchanged. A bad bit order or a leaked FA event would show up there.

// File: rtl/ps2_kbd_pkg.sv
package ps2_kbd_pkg;
  typedef enum logic [2:0] {
    TX_IDLE, TX_INHIBIT, TX_REQ, TX_SHIFT, TX_ACK_WAIT
  } tx_state_t;

  localparam logic [7:0] BYTE_EXT  = 8'hE0;
  localparam logic [7:0] BYTE_BRK  = 8'hF0;
  localparam logic [7:0] CMD_LEDS  = 8'hED;
  localparam logic [7:0] RSP_ACK   = 8'hFA;
  localparam int         FRAME_BITS = 11;
endpackage

// File: rtl/ps2_line_sync.sv
module ps2_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic clk_line,
  input  logic dat_line,
  output logic fall,
  output logic dat_q
);
  logic [STAGES-1:0] c_sr, d_sr;
  logic              c_prev;

  always_ff @(posedge clk) begin
    if (rst) begin
      c_sr   <= '1;
      d_sr   <= '1;
      c_prev <= 1'b1;
      fall   <= 1'b0;
      dat_q  <= 1'b1;
    end else begin
      c_sr   <= {c_sr[STAGES-2:0], clk_line};
      d_sr   <= {d_sr[STAGES-2:0], dat_line};
      c_prev <= c_sr[STAGES-1];
      fall   <= c_prev & ~c_sr[STAGES-1];
      dat_q  <= d_sr[STAGES-1];
    end
  end
endmodule

// File: rtl/ps2_frame_rx.sv
module ps2_frame_rx
  import ps2_kbd_pkg::*;
#(
  parameter int GAP_CYC = 100000
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       hold,
  input  logic       fall,
  input  logic       dat,
  output logic       byte_valid,
  output logic [7:0] byte_data,
  output logic       frame_err,
  output logic       gap_tick
);
  localparam int TW = $clog2(GAP_CYC + 1);

  logic [FRAME_BITS-1:0] sh;
  logic [FRAME_BITS-1:0] nxt;
  logic [3:0]            cnt;
  logic [TW-1:0]         timer;
  logic                  good;

  assign nxt  = {dat, sh[FRAME_BITS-1:1]};
  assign good = (nxt[0] == 1'b0) && (nxt[10] == 1'b1) && (^nxt[9:1] == 1'b1);

  always_ff @(posedge clk) begin
    if (rst) begin
      sh <= '0; cnt <= '0; timer <= '0;
      byte_valid <= 1'b0; byte_data <= '0; frame_err <= 1'b0; gap_tick <= 1'b0;
    end else begin
      byte_valid <= 1'b0;
      frame_err  <= 1'b0;
      gap_tick   <= 1'b0;
      if (hold) begin
        cnt   <= '0;
        timer <= '0;
      end else if (fall) begin
        timer <= '0;
        sh    <= nxt;
        if (cnt == 4'(FRAME_BITS - 1)) begin
          cnt <= '0;
          if (good) begin
            byte_valid <= 1'b1;
            byte_data  <= nxt[8:1];
          end else begin
            frame_err <= 1'b1;
          end
        end else begin
          cnt <= cnt + 4'd1;
        end
      end else if (timer != TW'(GAP_CYC)) begin
        timer <= timer + TW'(1);
        if (timer == TW'(GAP_CYC - 1)) begin
          gap_tick <= 1'b1;
          cnt      <= '0;
        end
      end
    end
  end
endmodule

// File: rtl/ps2_prefix_dec.sv
module ps2_prefix_dec
  import ps2_kbd_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       byte_valid,
  input  logic [7:0] byte_data,
  input  logic       consume,
  input  logic       gap_tick,
  output logic       ev_valid,
  output logic [7:0] ev_code,
  output logic       ev_break,
  output logic       ev_ext
);
  logic brk_p, ext_p;

  always_ff @(posedge clk) begin
    if (rst) begin
      brk_p <= 1'b0; ext_p <= 1'b0;
      ev_valid <= 1'b0; ev_code <= '0; ev_break <= 1'b0; ev_ext <= 1'b0;
    end else begin
      ev_valid <= 1'b0;
      if (gap_tick) begin
        brk_p <= 1'b0;
        ext_p <= 1'b0;
      end
      if (byte_valid && !consume) begin
        if (byte_data == BYTE_EXT) begin
          ext_p <= 1'b1;
        end else if (byte_data == BYTE_BRK) begin
          brk_p <= 1'b1;
        end else begin
          ev_valid <= 1'b1;
          ev_code  <= byte_data;
          ev_break <= brk_p;
          ev_ext   <= ext_p;
          brk_p    <= 1'b0;
          ext_p    <= 1'b0;
        end
      end
    end
  end
endmodule

// File: rtl/ps2_led_tx.sv
module ps2_led_tx
  import ps2_kbd_pkg::*;
#(
  parameter int INHIBIT_CYC = 5000
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       req,
  input  logic [2:0] mask,
  input  logic       fall,
  input  logic       byte_valid,
  input  logic [7:0] byte_data,
  output logic       clk_oe,
  output logic       data_oe,
  output logic       busy,
  output logic       hold_rx,
  output logic       consume
);
  localparam int CW = $clog2(INHIBIT_CYC + 1);

  tx_state_t     state;
  logic          phase;
  logic [CW-1:0] cnt;
  logic [3:0]    bitn;
  logic [7:0]    tx_byte;
  logic [2:0]    mask_q;

  assign busy    = (state != TX_IDLE);
  assign hold_rx = (state == TX_INHIBIT) || (state == TX_REQ) || (state == TX_SHIFT);
  assign consume = (state == TX_ACK_WAIT);

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= TX_IDLE; phase <= 1'b0; cnt <= '0; bitn <= '0;
      tx_byte <= '0; mask_q <= '0; clk_oe <= 1'b0; data_oe <= 1'b0;
    end else begin
      case (state)
        TX_IDLE: begin
          if (req) begin
            mask_q  <= mask;
            tx_byte <= CMD_LEDS;
            phase   <= 1'b0;
            cnt     <= '0;
            clk_oe  <= 1'b1;
            state   <= TX_INHIBIT;
          end
        end
        TX_INHIBIT: begin
          cnt <= cnt + CW'(1);
          if (cnt == CW'(INHIBIT_CYC - 1)) begin
            data_oe <= 1'b1;
            state   <= TX_REQ;
          end
        end
        TX_REQ: begin
          clk_oe <= 1'b0;
          bitn   <= '0;
          state  <= TX_SHIFT;
        end
        TX_SHIFT: begin
          if (fall) begin
            bitn <= bitn + 4'd1;
            if (bitn < 4'd8)       data_oe <= ~tx_byte[bitn[2:0]];
            else if (bitn == 4'd8) data_oe <= ^tx_byte;
            else if (bitn == 4'd9) data_oe <= 1'b0;
            else                   state   <= TX_ACK_WAIT;
          end
        end
        TX_ACK_WAIT: begin
          if (byte_valid) begin
            if (byte_data == RSP_ACK && !phase) begin
              phase   <= 1'b1;
              tx_byte <= {5'b0, mask_q};
              cnt     <= '0;
              clk_oe  <= 1'b1;
              state   <= TX_INHIBIT;
            end else begin
              state <= TX_IDLE;
            end
          end
        end
        default: state <= TX_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/ps2_kbd_host.sv
module ps2_kbd_host
  import ps2_kbd_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int GAP_CYC     = 100000,
  parameter int INHIBIT_CYC = 5000
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       ps2_clk_i,
  input  logic       ps2_data_i,
  output logic       ps2_clk_oe,
  output logic       ps2_data_oe,
  input  logic       led_req,
  input  logic [2:0] led_mask,
  output logic       led_busy,
  output logic       key_valid,
  output logic [7:0] key_code,
  output logic       key_break,
  output logic       key_ext,
  output logic       frame_err
);
  logic       fall, dat_s, hold_rx, consume, gap_tick;
  logic       rx_valid;
  logic [7:0] rx_byte;

  ps2_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .clk_line(ps2_clk_i), .dat_line(ps2_data_i),
    .fall(fall), .dat_q(dat_s)
  );

  ps2_frame_rx #(.GAP_CYC(GAP_CYC)) u_rx (
    .clk(clk), .rst(rst), .hold(hold_rx), .fall(fall), .dat(dat_s),
    .byte_valid(rx_valid), .byte_data(rx_byte), .frame_err(frame_err),
    .gap_tick(gap_tick)
  );

  ps2_prefix_dec u_dec (
    .clk(clk), .rst(rst), .byte_valid(rx_valid), .byte_data(rx_byte),
    .consume(consume), .gap_tick(gap_tick), .ev_valid(key_valid),
    .ev_code(key_code), .ev_break(key_break), .ev_ext(key_ext)
  );

  ps2_led_tx #(.INHIBIT_CYC(INHIBIT_CYC)) u_tx (
    .clk(clk), .rst(rst), .req(led_req), .mask(led_mask), .fall(fall),
    .byte_valid(rx_valid), .byte_data(rx_byte), .clk_oe(ps2_clk_oe),
    .data_oe(ps2_data_oe), .busy(led_busy), .hold_rx(hold_rx),
    .consume(consume)
  );
endmodule

// File: rtl/ps2_kbd_host_chk.sv
module ps2_kbd_host_chk (
  input logic       clk,
  input logic       rst,
  input logic       ps2_clk_oe,
  input logic       ps2_data_oe,
  input logic       led_busy,
  input logic       key_valid,
  input logic [7:0] key_code,
  input logic       frame_err
);
  assert_pulse_excl_R11: assert property (@(posedge clk) disable iff (rst)
    $onehot0({key_valid, frame_err}));

  assert_single_event_R11: assert property (@(posedge clk) disable iff (rst)
    key_valid |=> !key_valid);

  assert_no_prefix_out_R3: assert property (@(posedge clk) disable iff (rst)
    key_valid |-> (key_code != 8'hE0 && key_code != 8'hF0));

  assert_idle_release_R9: assert property (@(posedge clk) disable iff (rst)
    !led_busy |-> (!ps2_clk_oe && !ps2_data_oe));

  assert_inhibit_first_R6: assert property (@(posedge clk) disable iff (rst)
    $rose(ps2_clk_oe) |-> !ps2_data_oe);

  assert_release_with_start_R6: assert property (@(posedge clk) disable iff (rst)
    $fell(ps2_clk_oe) |-> ps2_data_oe);
endmodule

bind ps2_kbd_host ps2_kbd_host_chk u_chk (
  .clk(clk), .rst(rst), .ps2_clk_oe(ps2_clk_oe), .ps2_data_oe(ps2_data_oe),
  .led_busy(led_busy), .key_valid(key_valid), .key_code(key_code),
  .frame_err(frame_err)
);

// File: tb/ps2_kbd_host_bench.sv
module ps2_kbd_host_bench;
  localparam int GAP = 100;
  localparam int INH = 30;
  localparam int H   = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic kb_clk = 1'b1, kb_dat = 1'b1;
  logic led_req = 1'b0;
  logic [2:0] led_mask = '0;
  logic ps2_clk_oe, ps2_data_oe, led_busy, key_valid, key_break, key_ext, frame_err;
  logic [7:0] key_code;
  logic clk_line, dat_line;

  int checks = 0, errors = 0, ev_cnt = 0, err_cnt = 0;
  logic [7:0] last_code;
  logic last_brk, last_ext;

  always #2 clk = ~clk;

  assign clk_line = kb_clk & ~ps2_clk_oe;
  assign dat_line = kb_dat & ~ps2_data_oe;

  ps2_kbd_host #(.SYNC_STAGES(2), .GAP_CYC(GAP), .INHIBIT_CYC(INH)) u_ps2_kbd_host (
    .clk(clk), .rst(rst), .ps2_clk_i(clk_line), .ps2_data_i(dat_line),
    .ps2_clk_oe(ps2_clk_oe), .ps2_data_oe(ps2_data_oe), .led_req(led_req),
    .led_mask(led_mask), .led_busy(led_busy), .key_valid(key_valid),
    .key_code(key_code), .key_break(key_break), .key_ext(key_ext),
    .frame_err(frame_err)
  );

  always @(negedge clk) begin
    if (!rst) begin
      if (key_valid) begin
        ev_cnt++; last_code = key_code; last_brk = key_break; last_ext = key_ext;
      end
      if (frame_err) err_cnt++;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(posedge clk);
  endtask

  // bad: 0 good, 1 start=1, 2 wrong parity, 3 stop=0
  task automatic send_bits(input logic [7:0] b, input int bad, input int nbits);
    logic [10:0] f;
    f = {bad == 3 ? 1'b0 : 1'b1, (~^b) ^ (bad == 2), b, bad == 1 ? 1'b1 : 1'b0};
    for (int i = 0; i < nbits; i++) begin
      kb_dat = f[i];
      wait_cyc(H); kb_clk = 1'b0;
      wait_cyc(H); kb_clk = 1'b1;
    end
    kb_dat = 1'b1;
    wait_cyc(2 * H);
  endtask

  task automatic send_key(input logic [7:0] code, input bit brk, input bit ext,
                          input string req);
    int snap;
    snap = ev_cnt;
    if (ext) send_bits(8'hE0, 0, 11);
    if (brk) send_bits(8'hF0, 0, 11);
    send_bits(code, 0, 11);
    check(ev_cnt == snap + 1, req, ev_cnt - snap, 1);
    check({last_code, last_brk, last_ext} == {code, brk, ext}, req,
          {last_code, last_brk, last_ext}, {code, brk, ext});
  endtask

  // model keyboard receiving one host byte
  task automatic kb_recv(output logic [7:0] b, output bit ok, output int inh);
    logic [9:0] bits;
    inh = 0;
    while (clk_line !== 1'b0) @(negedge clk);
    while (clk_line === 1'b0) begin inh++; @(negedge clk); end
    ok = (dat_line === 1'b0);
    wait_cyc(H);
    for (int i = 0; i < 10; i++) begin
      kb_clk = 1'b0; wait_cyc(H);
      kb_clk = 1'b1; wait_cyc(H);
      bits[i] = dat_line;
    end
    kb_dat = 1'b0; kb_clk = 1'b0; wait_cyc(H);
    kb_clk = 1'b1; wait_cyc(H); kb_dat = 1'b1;
    wait_cyc(2 * H);
    b  = bits[7:0];
    ok = ok && (^bits[8:0] == 1'b1) && bits[9];
  endtask

  task automatic led_exchange(input logic [2:0] m, input bit second_req);
    logic [7:0] b; bit ok; int inh, snap, esnap;
    snap = ev_cnt; esnap = err_cnt;
    @(negedge clk); led_mask = m; led_req = 1'b1;
    @(negedge clk); led_req = 1'b0;
    check(led_busy == 1'b1, "R9 busy", led_busy, 1);
    if (second_req) begin
      led_mask = ~m; led_req = 1'b1; @(negedge clk); led_req = 1'b0;
    end
    kb_recv(b, ok, inh);
    check(inh >= INH, "R6 inhibit", inh, INH);
    check(ok && b == 8'hED, "R7 command", b, 8'hED);
    send_bits(8'hFA, 0, 11);
    check(led_busy == 1'b1, "R7 busy mid", led_busy, 1);
    kb_recv(b, ok, inh);
    check(ok && b == {5'b0, m}, "R7 mask", b, {5'b0, m});
    send_bits(8'hFA, 0, 11);
    check(led_busy == 1'b0, "R9 done", led_busy, 0);
    check(ev_cnt == snap && err_cnt == esnap, "R7 no ack event", ev_cnt - snap, 0);
  endtask

  initial begin
    wait_cyc(200000);
    errors++; checks++;
    $display("FAIL watchdog expired actual=hang expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [7:0] b; bit ok; int inh, snap;
    wait_cyc(4);
    @(negedge clk); rst = 1'b0;
    @(negedge clk);
    // R10: reset state
    check(!ps2_clk_oe && !ps2_data_oe && !led_busy && !key_valid && !frame_err,
          "R10 reset", {ps2_clk_oe, ps2_data_oe, led_busy}, 0);
    wait_cyc(GAP + 10);

    // R1: every plain code
    for (int c = 0; c < 256; c++)
      if (c != 8'hE0 && c != 8'hF0) send_key(8'(c), 1'b0, 1'b0, "R1 make");

    // R2/R3: prefix patterns across a spread of codes
    for (int c = 3; c < 256; c += 16) begin
      send_key(8'(c), 1'b1, 1'b0, "R2 break");
      send_key(8'(c), 1'b0, 1'b1, "R3 ext");
      send_key(8'(c), 1'b1, 1'b1, "R3 ext break");
    end

    // R4: each framing fault
    for (int k = 1; k <= 3; k++) begin
      snap = err_cnt; inh = ev_cnt;
      send_bits(8'h1C, k, 11);
      check(err_cnt == snap + 1, "R4 err pulse", err_cnt - snap, 1);
      check(ev_cnt == inh, "R4 no event", ev_cnt - inh, 0);
    end
    send_key(8'h1C, 1'b0, 1'b0, "R4 recover");

    // R5: pending prefix dropped after gap
    send_bits(8'hE0, 0, 11);
    wait_cyc(GAP + 20);
    send_key(8'h2A, 1'b0, 1'b0, "R5 prefix timeout");
    // R5: partial frame dropped after gap
    send_bits(8'h55, 0, 5);
    wait_cyc(GAP + 20);
    send_key(8'h3B, 1'b0, 1'b0, "R5 partial timeout");

    // R6/R7/R9: all masks
    for (int m = 0; m < 8; m++) led_exchange(3'(m), m == 5);

    // R8: wrong answer aborts
    snap = ev_cnt; inh = err_cnt;
    @(negedge clk); led_mask = 3'b010; led_req = 1'b1;
    @(negedge clk); led_req = 1'b0;
    kb_recv(b, ok, inh);
    send_bits(8'hFE, 0, 11);
    check(led_busy == 1'b0, "R8 abort", led_busy, 0);
    check(ev_cnt == snap, "R8 dropped", ev_cnt - snap, 0);
    send_key(8'h21, 1'b0, 1'b0, "R8 after abort");

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule